// File: doc/BRIEF.md
# Shared Bit Counting Unit

This block counts bits in a data word in one of three ways: the number of set bits, the number of zero bits below the lowest one, or the number of zero bits above the highest one. All three counts use one shared chain of single-bit counting cells. The cells walk an internal bit vector from its low end. For the leading-zero count, the operand enters the vector in reversed bit order, so its top zeros sit at the low end of the vector. For the two zero counts, each cell passes an enable to the next cell only while it sees a zero. For the population count, every cell is enabled.

The count is at most the word width. It is returned zero-extended to the full word width. The counting logic itself is combinational. A thin registered stage captures the result one clock after an input is marked valid and holds it until the next valid input arrives. The word width is a parameter and defaults to 32.

Top module: `bitcnt_unit`

## Requirements
- R1: With op code 0, the result is the number of one bits in the operand. An all-ones operand gives WIDTH.
- R2: With op code 1, the result is the number of consecutive zero bits starting at bit 0, stopping at the first one bit.
- R3: With op code 2, the result is the number of consecutive zero bits starting at bit WIDTH-1, stopping at the first one bit.
- R4: An all-zero operand gives WIDTH for both op code 1 and op code 2, and 0 for op code 0.
- R5: Op code 3 gives a result of zero for every operand.
- R6: All result bits above the count field (bit clog2(WIDTH+1) and up) are always zero, and the count never exceeds WIDTH.
- R7: The result and out_valid change one clock after a cycle with in_valid high. When in_valid is low, out_valid drops and out_result keeps its last value, whatever the operand and op inputs do.
- R8: While rst is high, out_valid and out_result are cleared to zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Marks the operand and op code as a request to capture |
| in_operand | input | WIDTH | Word to count |
| in_op | input | 2 | 0 population, 1 trailing zeros, 2 leading zeros, 3 none |
| out_valid | output | 1 | High in the cycle after an accepted request |
| out_result | output | WIDTH | Registered count, zero-extended |

## Verification
A broken enable link in the cell chain causes an error at the first operand whose lowest (or, after reversal, highest) one bit lies beyond that link. The error shows as a count that is too large or too small, one clock after the request. The single-one sweeps at every bit position find such a fault within one pass of the width. A fault in the reversal or in the op decode changes the result of the very next request with the affected op code. A fault in the masking of the reserved op code is caught the same way. The exhaustive sweep of an 8-bit instance covers every operand pattern, and the 32-bit sweeps test the full chain length.

// File: rtl/bitcnt_pkg.sv
package bitcnt_pkg;

    typedef enum logic [1:0] {
        BC_POP  = 2'd0,
        BC_TZC  = 2'd1,
        BC_LZC  = 2'd2,
        BC_NONE = 2'd3
    } bc_op_e;

    typedef struct packed {
        logic active;      // produce a count at all
        logic chained;     // cell enable ripples from the low end
        logic reversed;    // operand enters the vector bit-reversed
        logic zeros;       // cells count inverted operand bits
    } bc_ctrl_t;

    function automatic bc_ctrl_t bc_decode(input bc_op_e op);
        bc_ctrl_t c;
        c = '0;
        unique case (op)
            BC_POP: begin
                c.active = 1'b1;
            end
            BC_TZC: begin
                c.active  = 1'b1;
                c.chained = 1'b1;
                c.zeros   = 1'b1;
            end
            BC_LZC: begin
                c.active   = 1'b1;
                c.chained  = 1'b1;
                c.zeros    = 1'b1;
                c.reversed = 1'b1;
            end
            default: c = '0;
        endcase
        return c;
    endfunction

endpackage

// File: rtl/bitcnt_steer.sv
module bitcnt_steer
    import bitcnt_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0] operand,
    input  bc_ctrl_t         ctrl,
    output logic [WIDTH-1:0] vec
);
    logic [WIDTH-1:0] flipped;

    generate
        for (genvar i = 0; i < WIDTH; i++) begin : g_flip
            assign flipped[i] = operand[WIDTH-1-i];
        end
    endgenerate

    always_comb begin
        vec = ctrl.reversed ? flipped : operand;
        if (ctrl.zeros) begin
            vec = ~vec;
        end
    end

endmodule

// File: rtl/bitcnt_cell_array.sv
module bitcnt_cell_array #(
    parameter int WIDTH = 32,
    parameter int CNT_W = $clog2(WIDTH + 1)
) (
    input  logic [WIDTH-1:0] vec,
    input  logic             chained,
    output logic [CNT_W-1:0] count
);
    logic [WIDTH-1:0] en;
    logic [CNT_W-1:0] psum [WIDTH+1];

    assign en[0]   = 1'b1;
    assign psum[0] = '0;

    generate
        for (genvar i = 0; i < WIDTH; i++) begin : g_cell
            if (i > 0) begin : g_link
                assign en[i] = chained ? (en[i-1] & vec[i-1]) : 1'b1;
            end
            assign psum[i+1] = psum[i] + CNT_W'(en[i] & vec[i]);
        end
    endgenerate

    assign count = psum[WIDTH];

    // R6: the chain can never count past the word width
    always_comb begin
        if (!$isunknown(count)) begin
            a_r6_count_bound: assert (int'(count) <= WIDTH)
                else $error("count %0d exceeds width", count);
        end
    end

endmodule

// File: rtl/bitcnt_core.sv
module bitcnt_core
    import bitcnt_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0] operand,
    input  bc_op_e           op,
    output logic [WIDTH-1:0] result
);
    localparam int CNT_W = $clog2(WIDTH + 1);

    bc_ctrl_t         ctrl;
    logic [WIDTH-1:0] vec;
    logic [CNT_W-1:0] count;

    assign ctrl = bc_decode(op);

    bitcnt_steer #(.WIDTH(WIDTH)) u_steer (
        .operand (operand),
        .ctrl    (ctrl),
        .vec     (vec)
    );

    bitcnt_cell_array #(.WIDTH(WIDTH), .CNT_W(CNT_W)) u_cells (
        .vec     (vec),
        .chained (ctrl.chained),
        .count   (count)
    );

    assign result = ctrl.active ? {{(WIDTH-CNT_W){1'b0}}, count} : '0;

endmodule

// File: rtl/bitcnt_unit.sv
module bitcnt_unit
    import bitcnt_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    input  logic [WIDTH-1:0] in_operand,
    input  logic [1:0]       in_op,
    output logic             out_valid,
    output logic [WIDTH-1:0] out_result
);
    localparam int CNT_W = $clog2(WIDTH + 1);

    logic [WIDTH-1:0] core_result;

    bitcnt_core #(.WIDTH(WIDTH)) u_core (
        .operand (in_operand),
        .op      (bc_op_e'(in_op)),
        .result  (core_result)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid  <= 1'b0;
            out_result <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                out_result <= core_result;
            end
        end
    end

    a_r7_valid_follows: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);

    a_r7_hold_result: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> (!out_valid && $stable(out_result)));

    a_r5_reserved_zero: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_op == 2'd3) |=> (out_result == '0));

    a_r4_zero_operand: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_operand == '0 && (in_op == 2'd1 || in_op == 2'd2))
            |=> (out_result == WIDTH'(WIDTH)));

    a_r1_all_ones: assert property (@(posedge clk) disable iff (rst)
        (in_valid && (&in_operand) && in_op == 2'd0)
            |=> (out_result == WIDTH'(WIDTH)));

    a_r6_upper_clear: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> (out_result >> CNT_W) == '0);

endmodule

// File: tb/tb_bitcnt_unit.sv
module tb_bitcnt_unit;

    logic        clk = 1'b0;
    logic        rst;
    logic        v32, v8;
    logic [31:0] opd32;
    logic [7:0]  opd8;
    logic [1:0]  op32, op8;
    logic        ov32, ov8;
    logic [31:0] res32;
    logic [7:0]  res8;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #5 clk = ~clk;

    bitcnt_unit #(.WIDTH(32)) dut (
        .clk(clk), .rst(rst), .in_valid(v32), .in_operand(opd32),
        .in_op(op32), .out_valid(ov32), .out_result(res32)
    );

    bitcnt_unit #(.WIDTH(8)) dut_small (
        .clk(clk), .rst(rst), .in_valid(v8), .in_operand(opd8),
        .in_op(op8), .out_valid(ov8), .out_result(res8)
    );

    function automatic int ref_count(input logic [31:0] v, input int w, input int op);
        int n = 0;
        case (op)
            0: for (int i = 0; i < w; i++) n += int'(v[i]);
            1: for (int i = 0; i < w; i++) begin
                   if (v[i]) break;
                   n++;
               end
            2: for (int i = w - 1; i >= 0; i--) begin
                   if (v[i]) break;
                   n++;
               end
            default: n = 0;
        endcase
        return n;
    endfunction

    function automatic string tag_of(input int op, input logic [31:0] v, input int w);
        if (op == 3) return "R5";
        if (v == 32'h0) return "R4";
        if (op == 0) return "R1";
        if (op == 1) return "R2";
        if (w > 0) return "R3";
        return "R3";
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // drive at a falling edge, sample at the next falling edge (one register)
    task automatic run32(input logic [31:0] v, input int op);
        int e;
        @(negedge clk);
        v32 = 1'b1; opd32 = v; op32 = 2'(op);
        @(negedge clk);
        v32 = 1'b0;
        e = ref_count(v, 32, op);
        check(tag_of(op, v, 32), res32, 32'(e));
        check("R7_valid", {31'b0, ov32}, 32'd1);
    endtask

    task automatic run8(input logic [7:0] v, input int op);
        int e;
        @(negedge clk);
        v8 = 1'b1; opd8 = v; op8 = 2'(op);
        @(negedge clk);
        v8 = 1'b0;
        e = ref_count({24'b0, v}, 8, op);
        check(tag_of(op, {24'b0, v}, 8), {24'b0, res8}, 32'(e));
        check("R6_upper", {28'b0, res8[7:4]}, 32'd0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [31:0] hold;
        rst = 1'b1; v32 = 1'b0; v8 = 1'b0;
        opd32 = '0; op32 = '0; opd8 = '0; op8 = '0;
        repeat (3) @(negedge clk);
        // R8: reset state
        check("R8_valid", {31'b0, ov32}, 32'd0);
        check("R8_result", res32, 32'd0);
        check("R8_small", {23'b0, ov8, res8}, 32'd0);
        rst = 1'b0;

        // corners for the 32-bit unit
        for (int op = 0; op < 4; op++) begin
            run32(32'h0, op);
            run32(32'hFFFF_FFFF, op);
            run32(32'h8000_0001, op);
        end
        // single set bit and single cleared bit at every position
        for (int b = 0; b < 32; b++) begin
            for (int op = 0; op < 4; op++) begin
                run32(32'h1 << b, op);
                run32(~(32'h1 << b), op);
            end
        end
        // random operands
        for (int k = 0; k < 1500; k++) begin
            run32($urandom, k % 4);
        end

        // R7: idle inputs must leave the registered result untouched
        run32(32'h0000_0100, 1);
        hold = res32;
        @(negedge clk);
        opd32 = 32'h0; op32 = 2'd2; v32 = 1'b0;
        @(negedge clk);
        check("R7_hold", res32, hold);
        check("R7_novalid", {31'b0, ov32}, 32'd0);

        // exhaustive sweep of the 8-bit unit
        for (int op = 0; op < 4; op++) begin
            for (int x = 0; x < 256; x++) begin
                run8(8'(x), op);
            end
        end

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule